// File: doc/BRIEF.md
# DMA Byte Mover

This block is the sequencer for one DMA channel. It moves bytes between a 24-bit wide-address side (the A side) and a 256-entry register page (the B side, addresses 0x2100 to 0x21FF). A pulse on `start` loads a complete channel setting from the `cfg_*` inputs. That setting covers:

- the bank and the 16-bit address on the A side
- the register offset on the B side
- a transfer mode that selects a repeating pattern of B offsets
- the copy direction
- the hold and step-down options for the A address
- the byte count

The engine then copies one byte per slot. Each copy is a read request followed by a write request on a single bus port. The port uses request and acknowledge signals, and a side flag says which bus the current request targets.

The engine also watches for one illegal loopback: work RAM on the A side paired with the work-RAM data port at B offset 0x80. In that case it does not perform a real copy. With a read from A, both accesses are dropped and only the slot time is spent. With a read from B, the read is skipped and a fill value is written to A. `busy` stays high for the whole run. `done` pulses once when the last byte's slot has ended.

Top module: `dma_byte_mover`

## Requirements
- R1: After reset, `busy`, `done` and `bus_req` are all low. `bus_req` is never high while `busy` is low.
- R2: An A-side access has `bus_b_sel`=0 and `bus_addr` = {bank, 16-bit address}. A B-side access has `bus_b_sel`=1 and `bus_addr` = {8'h00, 8'h21, low byte}, where the low byte is (B offset + pattern entry) mod 256.
- R3: With `cfg_dir`=0, each byte reads A and then writes the value read to B. With `cfg_dir`=1, each byte reads B and then writes the value read to A.
- R4: The mode selects the offset pattern, one entry per byte, and the pattern restarts after its last entry. The patterns by mode are:
  - mode 0: 0
  - mode 1: 0,1
  - mode 2: 0,0
  - mode 3: 0,0,1,1
  - mode 4: 0,1,2,3
  - mode 5: 0,1,0,1
  - mode 6: 0,0
  - mode 7: 0,0,1,1
- R5: After each byte, the 16-bit A address is handled as follows, and the bank never changes:
  - held when `cfg_fixed`=1
  - otherwise decremented when `cfg_decr`=1
  - otherwise incremented
  - the step wraps within 16 bits
- R6: A run moves `cfg_count` bytes. A count of zero moves 2^CNT_W bytes.
- R7: Each byte slot lasts BYTE_CLKS (8) cycles. When acknowledge is immediate, the read request occupies the first cycle of the slot and the write request the second, and `busy` stays high for exactly 8 cycles per byte.
- R8: An A address is work RAM if either of these holds:
  - its bank is 0x7E or 0x7F
  - its bank is in 0x00–0x3F or 0x80–0xBF and the 16-bit address is below 0x2000
- R9: When the B low byte is 0x80, the A address is work RAM and `cfg_dir`=0, the byte issues no request but still takes its full 8-cycle slot.
- R10: When the B low byte is 0x80, the A address is work RAM and `cfg_dir`=1, the B read is skipped. After SKIP_CLKS (4) idle cycles, the value 0xFF is written to the A address in the fifth cycle of the slot.
- R11: `done` is high for exactly one cycle: the first cycle after the last slot, with `busy` already low.
- R12: A `start` pulse while `busy` is high is ignored, and the running transfer continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (one cycle per master clock) |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Load the configuration and begin a run (used only when idle) |
| cfg_bank | input | 8 | A-side bank |
| cfg_addr | input | 16 | A-side starting address within the bank |
| cfg_boff | input | 8 | B-side register offset |
| cfg_mode | input | 3 | Offset pattern selector |
| cfg_dir | input | 1 | 0: A to B, 1: B to A |
| cfg_fixed | input | 1 | Hold the A address |
| cfg_decr | input | 1 | Step the A address downward |
| cfg_count | input | CNT_W | Byte count, 0 means 2^CNT_W |
| bus_req | output | 1 | Bus request |
| bus_we | output | 1 | 1: write, 0: read |
| bus_b_sel | output | 1 | 1: the request targets the B side |
| bus_addr | output | 24 | Request address |
| bus_wdata | output | 8 | Write data |
| bus_ack | input | 1 | Request completes in this cycle |
| bus_rdata | input | 8 | Read data, valid with `bus_ack` |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle end-of-run pulse |

## Verification
Each fault in the internal state has a visible signature at the ports, and most show within one slot:

- A wrong pattern index or a wrong offset sum shows up as a B-side address that differs on the first byte where the pattern entry matters.
- A wrong A address step shows up on the second byte's A access.
- A wrong loopback classification makes a request appear in a slot that should be silent, or makes a read replace the 0xFF fill. The bench sees that within the same 8-cycle slot.
- A slot counter fault moves every later request off its slot grid. It also changes the `busy` length by a whole number of cycles.
- A remaining-count fault shows only at the end of the run, as a wrong number of bytes or a misplaced `done` pulse.

// File: rtl/dmx_pkg.sv
package dmx_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_READ,
      ST_WRITE,
      ST_HOLD,
      ST_PAD
   } dmx_state_e;

   typedef enum logic [1:0] {
      BK_NORMAL,
      BK_SKIP,
      BK_FILL
   } dmx_kind_e;

   localparam logic [7:0] B_PAGE   = 8'h21;
   localparam logic [7:0] PORT_OFF = 8'h80;
   localparam logic [7:0] FILL_VAL = 8'hFF;

   // offset pattern entry for a mode and position
   function automatic logic [1:0] pat_off(input logic [2:0] mode, input logic [1:0] idx);
      logic [1:0] r;
      case (mode)
         3'd0:          r = 2'd0;
         3'd1:          r = {1'b0, idx[0]};
         3'd2, 3'd6:    r = 2'd0;
         3'd3, 3'd7:    r = {1'b0, idx[1]};
         3'd4:          r = idx;
         default:       r = {1'b0, idx[0]};
      endcase
      return r;
   endfunction

   // pattern length for a mode
   function automatic logic [2:0] pat_len(input logic [2:0] mode);
      logic [2:0] r;
      case (mode)
         3'd0:                   r = 3'd1;
         3'd1, 3'd2, 3'd6:       r = 3'd2;
         default:                r = 3'd4;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/dmx_addr_step.sv
module dmx_addr_step #(
   parameter int ADDR_W = 16
) (
   input  logic [ADDR_W-1:0] cur,
   input  logic              hold,
   input  logic              down,
   output logic [ADDR_W-1:0] nxt
);
   always_comb begin
      if (hold)      nxt = cur;
      else if (down) nxt = cur - 1'b1;
      else           nxt = cur + 1'b1;
   end
endmodule

// File: rtl/dmx_wram_decode.sv
module dmx_wram_decode #(
   parameter logic [7:0] HI_BANK  = 8'h7E,
   parameter int         LOW_BITS = 3
) (
   input  logic [11:0] region,
   output logic        is_wram
);
   logic [7:0] bank;
   logic [3:0] page;
   logic       hi_hit;
   logic       lo_hit;

   assign bank = region[11:4];
   assign page = region[3:0];

   assign hi_hit = (bank[7:1] == HI_BANK[7:1]);
   assign lo_hit = !bank[6] && (page[3 -: LOW_BITS] == '0);
   assign is_wram = hi_hit || lo_hit;

   generate
      if (LOW_BITS < 1 || LOW_BITS > 4) begin : g_bad_low
         $error("dmx_wram_decode: LOW_BITS out of range");
      end
   endgenerate
endmodule

// File: rtl/dmx_byte_plan.sv
module dmx_byte_plan
   import dmx_pkg::*;
(
   input  logic [7:0]  bank,
   input  logic [15:0] a_addr,
   input  logic [7:0]  boff,
   input  logic [2:0]  mode,
   input  logic [1:0]  idx,
   input  logic        dir,
   output logic [7:0]  b_low,
   output logic        a_wram,
   output dmx_kind_e   kind
);
   logic [1:0] off;

   assign off   = pat_off(mode, idx);
   assign b_low = boff + {6'd0, off};

   dmx_wram_decode u_wram (
      .region  ({bank, a_addr[15:12]}),
      .is_wram (a_wram)
   );

   always_comb begin
      if (b_low == PORT_OFF && a_wram) kind = dir ? BK_FILL : BK_SKIP;
      else                             kind = BK_NORMAL;
   end

   logic unused_a;
   assign unused_a = ^a_addr[11:0];
endmodule

// File: rtl/dma_byte_mover.sv
module dma_byte_mover
   import dmx_pkg::*;
#(
   parameter int CNT_W     = 16,
   parameter int BYTE_CLKS = 8,
   parameter int SKIP_CLKS = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [7:0]       cfg_bank,
   input  logic [15:0]      cfg_addr,
   input  logic [7:0]       cfg_boff,
   input  logic [2:0]       cfg_mode,
   input  logic             cfg_dir,
   input  logic             cfg_fixed,
   input  logic             cfg_decr,
   input  logic [CNT_W-1:0] cfg_count,
   output logic             bus_req,
   output logic             bus_we,
   output logic             bus_b_sel,
   output logic [23:0]      bus_addr,
   output logic [7:0]       bus_wdata,
   input  logic             bus_ack,
   input  logic [7:0]       bus_rdata,
   output logic             busy,
   output logic             done
);
   localparam int SLOT_W = $clog2(BYTE_CLKS) + 1;
   localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(BYTE_CLKS - 1);
   localparam logic [SLOT_W-1:0] HOLD_LAST = SLOT_W'(SKIP_CLKS - 1);
   localparam int REM_W = CNT_W + 1;

   generate
      if (BYTE_CLKS < SKIP_CLKS + 2) begin : g_bad_slot
         $error("dma_byte_mover: BYTE_CLKS must exceed SKIP_CLKS + 1");
      end
      if (SKIP_CLKS < 1) begin : g_bad_skip
         $error("dma_byte_mover: SKIP_CLKS must be at least 1");
      end
      if (CNT_W < 1 || CNT_W > 24) begin : g_bad_cnt
         $error("dma_byte_mover: CNT_W out of range");
      end
   endgenerate

   dmx_state_e        state_q;
   dmx_kind_e         kind_q;
   logic [7:0]        bank_q;
   logic [15:0]       a_q;
   logic [7:0]        boff_q;
   logic [2:0]        mode_q;
   logic              dir_q;
   logic              fixed_q;
   logic              decr_q;
   logic [REM_W-1:0]  remain_q;
   logic [1:0]        idx_q;
   logic [7:0]        blow_q;
   logic              wram_q;
   logic [SLOT_W-1:0] slot_q;
   logic [7:0]        data_q;
   logic              done_q;

   logic              start_ok;
   logic              slot_end;
   logic              last_byte;
   logic [SLOT_W-1:0] slot_inc;
   logic [15:0]       a_stepped;
   logic [1:0]        idx_adv;
   logic [7:0]        c_bank;
   logic [15:0]       c_addr;
   logic [7:0]        c_boff;
   logic [2:0]        c_mode;
   logic [1:0]        c_idx;
   logic              c_dir;
   logic [7:0]        c_blow;
   logic              c_wram;
   dmx_kind_e         c_kind;
   dmx_state_e        c_first;

   assign start_ok  = start && (state_q == ST_IDLE);
   assign slot_end  = (state_q == ST_PAD) && (slot_q >= SLOT_LAST);
   assign last_byte = (remain_q == REM_W'(1));
   assign slot_inc  = (slot_q == '1) ? slot_q : slot_q + 1'b1;
   assign idx_adv   = ({1'b0, idx_q} + 3'd1 == pat_len(mode_q)) ? 2'd0 : idx_q + 2'd1;

   dmx_addr_step #(.ADDR_W(16)) u_step (
      .cur  (a_q),
      .hold (fixed_q),
      .down (decr_q),
      .nxt  (a_stepped)
   );

   // settings of the byte about to begin
   always_comb begin
      if (start_ok) begin
         c_bank = cfg_bank;  c_addr = cfg_addr; c_boff = cfg_boff;
         c_mode = cfg_mode;  c_idx  = 2'd0;     c_dir  = cfg_dir;
      end else begin
         c_bank = bank_q;    c_addr = a_stepped; c_boff = boff_q;
         c_mode = mode_q;    c_idx  = idx_adv;   c_dir  = dir_q;
      end
   end

   dmx_byte_plan u_plan (
      .bank   (c_bank),
      .a_addr (c_addr),
      .boff   (c_boff),
      .mode   (c_mode),
      .idx    (c_idx),
      .dir    (c_dir),
      .b_low  (c_blow),
      .a_wram (c_wram),
      .kind   (c_kind)
   );

   always_comb begin
      case (c_kind)
         BK_SKIP: c_first = ST_PAD;
         BK_FILL: c_first = ST_HOLD;
         default: c_first = ST_READ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         kind_q   <= BK_NORMAL;
         bank_q   <= '0;
         a_q      <= '0;
         boff_q   <= '0;
         mode_q   <= '0;
         dir_q    <= 1'b0;
         fixed_q  <= 1'b0;
         decr_q   <= 1'b0;
         remain_q <= '0;
         idx_q    <= '0;
         blow_q   <= '0;
         wram_q   <= 1'b0;
         slot_q   <= '0;
         data_q   <= '0;
         done_q   <= 1'b0;
      end else begin
         done_q <= 1'b0;
         case (state_q)
            ST_IDLE: begin
               if (start_ok) begin
                  bank_q   <= cfg_bank;
                  a_q      <= cfg_addr;
                  boff_q   <= cfg_boff;
                  mode_q   <= cfg_mode;
                  dir_q    <= cfg_dir;
                  fixed_q  <= cfg_fixed;
                  decr_q   <= cfg_decr;
                  idx_q    <= 2'd0;
                  remain_q <= (cfg_count == '0) ? {1'b1, {CNT_W{1'b0}}} : {1'b0, cfg_count};
                  blow_q   <= c_blow;
                  wram_q   <= c_wram;
                  kind_q   <= c_kind;
                  slot_q   <= '0;
                  data_q   <= FILL_VAL;
                  state_q  <= c_first;
               end
            end
            ST_READ: begin
               slot_q <= slot_inc;
               if (bus_ack) begin
                  data_q  <= bus_rdata;
                  state_q <= ST_WRITE;
               end
            end
            ST_WRITE: begin
               slot_q <= slot_inc;
               if (bus_ack) state_q <= ST_PAD;
            end
            ST_HOLD: begin
               slot_q <= slot_inc;
               if (slot_q == HOLD_LAST) state_q <= ST_WRITE;
            end
            default: begin
               if (!slot_end) begin
                  slot_q <= slot_inc;
               end else if (last_byte) begin
                  state_q <= ST_IDLE;
                  done_q  <= 1'b1;
               end else begin
                  a_q      <= a_stepped;
                  idx_q    <= idx_adv;
                  remain_q <= remain_q - 1'b1;
                  blow_q   <= c_blow;
                  wram_q   <= c_wram;
                  kind_q   <= c_kind;
                  slot_q   <= '0;
                  data_q   <= FILL_VAL;
                  state_q  <= c_first;
               end
            end
         endcase
      end
   end

   assign bus_req   = (state_q == ST_READ) || (state_q == ST_WRITE);
   assign bus_we    = (state_q == ST_WRITE);
   assign bus_b_sel = (state_q == ST_WRITE) ^ dir_q;
   assign bus_addr  = bus_b_sel ? {8'h00, B_PAGE, blow_q} : {bank_q, a_q};
   assign bus_wdata = data_q;
   assign busy      = (state_q != ST_IDLE);
   assign done      = done_q;

   // R1
   req_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !bus_req);

   // R11
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R9
   port_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && bus_b_sel && bus_addr[7:0] == PORT_OFF) |-> !wram_q);

   // R10
   fill_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && bus_we && !bus_b_sel && wram_q && blow_q == PORT_OFF) |-> (bus_wdata == FILL_VAL));

   // R5
   fixed_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy) && fixed_q) |-> $stable(a_q));

   logic unused_kind;
   assign unused_kind = ^kind_q;
endmodule

// File: tb/dma_byte_mover_bench.sv
module dma_byte_mover_bench;
   localparam int CW = 8;
   localparam int MAXEV = 1024;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [7:0]    cfg_bank = '0;
   logic [15:0]   cfg_addr = '0;
   logic [7:0]    cfg_boff = '0;
   logic [2:0]    cfg_mode = '0;
   logic          cfg_dir = 1'b0;
   logic          cfg_fixed = 1'b0;
   logic          cfg_decr = 1'b0;
   logic [CW-1:0] cfg_count = '0;
   logic          bus_req, bus_we, bus_b_sel, busy, done;
   logic [23:0]   bus_addr;
   logic [7:0]    bus_wdata;
   logic          bus_ack;
   logic [7:0]    bus_rdata;

   int checks = 0;
   int fails = 0;
   int cyc = 0;
   int start_cyc = 0;

   always #10 clk = ~clk;

   dma_byte_mover #(.CNT_W(CW)) u_dma_byte_mover (
      .clk, .rst_n, .start, .cfg_bank, .cfg_addr, .cfg_boff, .cfg_mode,
      .cfg_dir, .cfg_fixed, .cfg_decr, .cfg_count,
      .bus_req, .bus_we, .bus_b_sel, .bus_addr, .bus_wdata, .bus_ack, .bus_rdata,
      .busy, .done
   );

   function automatic logic [7:0] a_val(input logic [23:0] a);
      return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'h5A;
   endfunction
   function automatic logic [7:0] b_val(input logic [7:0] o);
      return o ^ 8'hC3;
   endfunction

   assign bus_ack   = bus_req;
   assign bus_rdata = bus_b_sel ? b_val(bus_addr[7:0]) : a_val(bus_addr);

   // bus log
   int          ev_n = 0;
   logic        lg_we   [MAXEV];
   logic        lg_b    [MAXEV];
   logic [23:0] lg_addr [MAXEV];
   logic [7:0]  lg_data [MAXEV];
   int          lg_rel  [MAXEV];

   always @(posedge clk) begin
      if (rst_n && start && !busy) begin
         start_cyc = cyc;
         ev_n = 0;
      end
      if (rst_n && bus_req && bus_ack && ev_n < MAXEV) begin
         lg_we[ev_n]   = bus_we;
         lg_b[ev_n]    = bus_b_sel;
         lg_addr[ev_n] = bus_addr;
         lg_data[ev_n] = bus_wdata;
         lg_rel[ev_n]  = cyc - start_cyc;
         ev_n++;
      end
      cyc++;
   end

   // expected model
   int          ex_n;
   logic        ex_we   [MAXEV];
   logic        ex_b    [MAXEV];
   logic [23:0] ex_addr [MAXEV];
   logic [7:0]  ex_data [MAXEV];
   int          ex_rel  [MAXEV];

   function automatic int m_len(input int mode);
      case (mode)
         0: return 1;
         1, 2, 6: return 2;
         default: return 4;
      endcase
   endfunction
   function automatic int m_off(input int mode, input int k);
      case (mode)
         0, 2, 6: return 0;
         1, 5: return k % 2;
         3, 7: return k / 2;
         default: return k;
      endcase
   endfunction
   function automatic bit m_wram(input logic [7:0] bank, input logic [15:0] a);
      if (bank == 8'h7E || bank == 8'h7F) return 1'b1;
      if ((bank < 8'h40 || (bank >= 8'h80 && bank < 8'hC0)) && a < 16'h2000) return 1'b1;
      return 1'b0;
   endfunction

   task automatic add_ev(input logic we, input logic b, input logic [23:0] a,
                         input logic [7:0] d, input int rel);
      ex_we[ex_n] = we; ex_b[ex_n] = b; ex_addr[ex_n] = a; ex_data[ex_n] = d;
      ex_rel[ex_n] = rel; ex_n++;
   endtask

   task automatic build_expect(input logic [7:0] bank, input logic [15:0] addr,
         input logic [7:0] boff, input int mode, input logic dir, input logic fixed,
         input logic decr, input int nbytes);
      logic [15:0] a = addr;
      int ix = 0;
      ex_n = 0;
      for (int k = 0; k < nbytes; k++) begin
         logic [7:0]  bl = boff + 8'(m_off(mode, ix));
         logic [23:0] aa = {bank, a};
         logic [23:0] ba = {16'h0021, bl};
         if (bl == 8'h80 && m_wram(bank, a)) begin
            if (dir) add_ev(1'b1, 1'b0, aa, 8'hFF, 8*k + 5);
         end else if (!dir) begin
            add_ev(1'b0, 1'b0, aa, 8'h00, 8*k + 1);
            add_ev(1'b1, 1'b1, ba, a_val(aa), 8*k + 2);
         end else begin
            add_ev(1'b0, 1'b1, ba, 8'h00, 8*k + 1);
            add_ev(1'b1, 1'b0, aa, b_val(bl), 8*k + 2);
         end
         if (!fixed) a = decr ? a - 16'd1 : a + 16'd1;
         ix = (ix + 1) % m_len(mode);
      end
   endtask

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // launches a run, optionally pokes start mid-run, and compares
   task automatic run_case(input string tag, input logic [7:0] bank, input logic [15:0] addr,
         input logic [7:0] boff, input int mode, input logic dir, input logic fixed,
         input logic decr, input int count, input bit poke);
      int nb = (count == 0) ? (1 << CW) : count;
      int busy_n = 0;
      int done_n = 0;
      int done_busy = 0;
      int guard = 0;
      int bad = -1;
      bit seen = 0;
      build_expect(bank, addr, boff, mode, dir, fixed, decr, nb);
      @(negedge clk);
      cfg_bank = bank; cfg_addr = addr; cfg_boff = boff; cfg_mode = 3'(mode);
      cfg_dir = dir; cfg_fixed = fixed; cfg_decr = decr; cfg_count = CW'(count);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      while (!seen && guard < 20000) begin
         if (busy) busy_n++;
         if (done) begin done_n++; seen = 1; if (busy) done_busy++; end
         if (poke && guard == 3) begin
            cfg_bank = 8'h33; cfg_addr = 16'h4444; cfg_boff = 8'h10; cfg_mode = 3'd4;
            cfg_dir = ~dir; cfg_count = CW'(1);
            start = 1'b1;
         end else begin
            start = 1'b0;
         end
         guard++;
         @(negedge clk);
      end
      if (done) done_n++;
      chk(seen, {tag, " R11 done seen"}, seen, 1);
      chk(done_n == 1 && done_busy == 0, {tag, " R11 done width"}, done_n, 1);
      chk(busy_n == 8 * nb, {tag, " R7 R6 busy cycles"}, busy_n, 8 * nb);
      chk(ev_n == ex_n, {tag, " event count"}, ev_n, ex_n);
      for (int i = 0; i < ex_n && i < ev_n; i++) begin
         if (bad < 0 && (lg_we[i] != ex_we[i] || lg_b[i] != ex_b[i] || lg_addr[i] != ex_addr[i]
             || lg_rel[i] != ex_rel[i] || (ex_we[i] && lg_data[i] != ex_data[i])))
            bad = i;
      end
      if (bad >= 0)
         chk(1'b0, {tag, " event content"},
             int'({lg_we[bad], lg_b[bad], lg_addr[bad]}), int'({ex_we[bad], ex_b[bad], ex_addr[bad]}));
      else
         chk(1'b1, {tag, " event content"}, 0, 0);
   endtask

   task automatic t_reset;
      #1;
      chk(!busy, "R1 busy at reset", busy, 0);
      chk(!done, "R1 done at reset", done, 0);
      chk(!bus_req, "R1 req at reset", bus_req, 0);
   endtask

   task automatic t_a_to_b;
      run_case("R2 R3 R4 mode1 A->B", 8'h01, 16'h8000, 8'h18, 1, 1'b0, 1'b0, 1'b0, 4, 1'b0);
   endtask
   task automatic t_b_to_a_decr;
      run_case("R3 R4 R5 mode3 B->A decr wrap", 8'h02, 16'h0001, 8'h40, 3, 1'b1, 1'b0, 1'b1, 5, 1'b0);
   endtask
   task automatic t_fixed_wrap;
      run_case("R5 R2 mode4 fixed boff wrap", 8'h90, 16'h3456, 8'hFE, 4, 1'b0, 1'b1, 1'b0, 6, 1'b0);
   endtask
   task automatic t_modes;
      run_case("R4 mode5", 8'h40, 16'h0000, 8'h22, 5, 1'b0, 1'b0, 1'b0, 5, 1'b0);
      run_case("R4 mode7", 8'hC1, 16'h1000, 8'h30, 7, 1'b1, 1'b0, 1'b0, 5, 1'b0);
   endtask
   task automatic t_skip;
      run_case("R9 skip A->B", 8'h7E, 16'h5000, 8'h80, 0, 1'b0, 1'b0, 1'b0, 3, 1'b0);
   endtask
   task automatic t_fill;
      run_case("R10 fill B->A", 8'h00, 16'h1000, 8'h80, 0, 1'b1, 1'b0, 1'b0, 2, 1'b0);
   endtask
   task automatic t_mixed;
      run_case("R9 mixed port", 8'h7F, 16'hFFFE, 8'h7F, 1, 1'b0, 1'b0, 1'b0, 4, 1'b0);
   endtask
   task automatic t_decode;
      run_case("R8 bank40 not wram", 8'h40, 16'h0000, 8'h80, 0, 1'b0, 1'b0, 1'b0, 1, 1'b0);
      run_case("R8 bank3F low wram", 8'h3F, 16'h1FFF, 8'h80, 0, 1'b0, 1'b0, 1'b0, 1, 1'b0);
      run_case("R8 bank80 2000 not wram", 8'h80, 16'h2000, 8'h80, 0, 1'b1, 1'b0, 1'b0, 1, 1'b0);
      run_case("R8 bankBF low wram", 8'hBF, 16'h0000, 8'h80, 0, 1'b1, 1'b0, 1'b0, 1, 1'b0);
   endtask
   task automatic t_ignore_start;
      run_case("R12 start while busy", 8'h05, 16'h2222, 8'h04, 2, 1'b0, 1'b0, 1'b0, 3, 1'b1);
   endtask
   task automatic t_zero_count;
      run_case("R6 zero count", 8'h06, 16'hFF00, 8'h01, 6, 1'b0, 1'b0, 1'b0, 0, 1'b0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=done", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_a_to_b();
      t_b_to_a_decr();
      t_fixed_wrap();
      t_modes();
      t_skip();
      t_fill();
      t_mixed();
      t_decode();
      t_ignore_start();
      t_zero_count();
      repeat (3) @(negedge clk);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule